// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It stores 32-bit words split into four byte lanes and has a depth set by a parameter. A register captures every control, address and data input on the rising clock edge. The array is accessed one cycle later, and read data then passes through a read register and an output register. The output bus is split into a data output and a drive enable. A board-level tristate combines the drive enable with the asynchronous output-enable input to form a shared data bus.

An access begins when either of two address strobes is sampled while all three chip enables are asserted. The strobe loads a burst base address, and a 2-bit counter then walks the low address bits through four words. A mode input chooses interleaved or linear order. An advance input steps the counter, and without it the current word is accessed again. Writes can target single byte lanes through a byte-write master control, or all lanes through a global write. A sleep input freezes the block without losing contents.

Top module: `sync_burst_sram`

## Requirements
- R1: An access sampled at rising edge n returns its read word on `rdata_o` after edge n+2. A burst of one strobe cycle followed by three advance cycles therefore delivers its four words on consecutive cycles.
- R2: A strobe sampled with `ce_ni`=0, `ce2_i`=1 and `ce2_ni`=0 loads the base address and zeroes the count. A strobe that takes effect while any chip enable is deasserted ends the burst, and no further access occurs until the next start.
- R3: `proc_stb_ni` low is ignored when `ce_ni` is high, and the active burst continues. `ctrl_stb_ni` low always takes effect.
- R4: `adv_ni` low, with no strobe, adds 1 modulo 4 to the count. With `adv_ni` high, the same word is accessed again.
- R5: The accessed address keeps the base's upper bits. With `interleave_i`=1, the low two bits are base[1:0] XOR count. With `interleave_i`=0, they are base[1:0] plus count, modulo 4.
- R6: With `byte_wr_ni`=0, each `lane_wr_ni[i]`=0 writes byte i, which is bits 8i+7..8i. With `byte_wr_ni`=1, the lane controls have no effect.
- R7: `all_wr_ni`=0 writes all four lanes, whatever the lane and byte-write controls are.
- R8: The cycle that starts a burst through `proc_stb_ni` is always a read, and the write controls are ignored. If both strobes are asserted in the same cycle, the processor-side strobe decides.
- R9: A read of a word written in the immediately preceding cycle returns the new data.
- R10: While the sampled `sleep_i` is 1, no burst starts, no read or write happens, and the base, count and active state hold.
- R11: `rdata_oe_o` is 1 exactly when the output register holds read data and `oe_ni` is 0. It follows `oe_ni` without waiting for a clock. After reset, `rdata_oe_o` and `rdata_o` are 0.
- R12: A write cycle produces no valid output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rdata_oe_o | output | 1 | Drive enable for the shared data bus |
| ce_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce2_ni | input | 1 | Chip enable, active low |
| proc_stb_ni | input | 1 | Processor-side address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| byte_wr_ni | input | 1 | Byte-write master enable, active low |
| lane_wr_ni | input | 4 | Per-lane write enables, active low |
| all_wr_ni | input | 1 | Global write of all lanes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| sleep_i | input | 1 | Low-power standby |

## Verification
On every cycle, the assertions check the burst counter. A start must leave the count at zero, advance must add one, a hold must keep the count, and sleep must freeze the whole burst state. They also check that a write never leaves a valid read word behind, and that read data moves into the output register one cycle after the read register.

Only the bench scenarios can show the rest. These are the address order across a full burst in both modes, correct lane merging and the suppressed lane writes, and the processor strobe being ignored while the primary enable is high. The same applies to pass-through data, the three-cycle latency of the first word, and the output enable following `oe_ni` between clock edges. The bench checks all of these against its own model of the memory.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef struct packed {
    logic             ce_n;
    logic             ce2;
    logic             ce2_n;
    logic             proc_stb_n;
    logic             ctrl_stb_n;
    logic             adv_n;
    logic             byte_wr_n;
    logic [LANES-1:0] lane_wr_n;
    logic             all_wr_n;
    logic             mode;
    logic             sleep;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, ce2: 1'b0, ce2_n: 1'b1,
                                proc_stb_n: 1'b1, ctrl_stb_n: 1'b1, adv_n: 1'b1,
                                byte_wr_n: 1'b1, lane_wr_n: '1, all_wr_n: 1'b1,
                                mode: 1'b1, sleep: 1'b0};

  function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] cnt,
                                           logic interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output ctl_t              ctl_o,
  output logic [AW-1:0]     addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= CTL_IDLE;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      ctl_o   <= ctl_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctl_t             ctl_i,
  input  logic [AW-1:0]    addr_i,
  output logic             acc_valid_o,
  output logic [AW-1:0]    acc_addr_o,
  output logic [LANES-1:0] acc_lanes_o
);
  logic [AW-1:0]    base_q, base_n;
  logic [1:0]       cnt_q, cnt_n;
  logic             active_q, active_n;
  logic             en_all, proc_hit, strobe, awake, start, desel, step;
  logic [LANES-1:0] wr_lanes;

  assign en_all   = ~ctl_i.ce_n & ctl_i.ce2 & ~ctl_i.ce2_n;
  assign proc_hit = ~ctl_i.proc_stb_n & ~ctl_i.ce_n;
  assign strobe   = proc_hit | ~ctl_i.ctrl_stb_n;
  assign awake    = ~ctl_i.sleep;
  assign start    = awake & strobe & en_all;
  assign desel    = awake & strobe & ~en_all;
  assign step     = awake & ~strobe & active_q & ~ctl_i.adv_n;

  always_comb begin
    base_n   = base_q;
    cnt_n    = cnt_q;
    active_n = active_q;
    if (start) begin
      base_n   = addr_i;
      cnt_n    = 2'd0;
      active_n = 1'b1;
    end else if (desel) begin
      active_n = 1'b0;
    end else if (step) begin
      cnt_n = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      base_q   <= base_n;
      cnt_q    <= cnt_n;
      active_q <= active_n;
    end
  end

  // global write overrides the byte-write master and lane enables
  assign wr_lanes    = ~ctl_i.all_wr_n ? '1 : (~ctl_i.byte_wr_n ? ~ctl_i.lane_wr_n : '0);
  assign acc_valid_o = awake & active_n;
  assign acc_addr_o  = {base_n[AW-1:2], burst_low(base_n[1:0], cnt_n, ctl_i.mode)};
  assign acc_lanes_o = (acc_valid_o && !(start && proc_hit)) ? wr_lanes : '0;

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == 2'd0) && active_q);
  assert_step_adds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> cnt_q == $past(cnt_q) + 2'd1);
  assert_hold_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake && !strobe && ctl_i.adv_n) |=> $stable(cnt_q));
  assert_sleep_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.sleep |=> $stable(cnt_q) && $stable(base_q) && $stable(active_q));
endmodule

// File: rtl/sbs_mem.sv
module sbs_mem
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [LANES-1:0]  acc_lanes_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WORD_W-1:0] rd_word;
  logic              is_read;

  assign is_read = acc_valid_i & ~|acc_lanes_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk_i) begin
      if (acc_valid_i && acc_lanes_i[l]) bank[acc_addr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
    end
    assign rd_word[l*BYTE_W +: BYTE_W] = bank[acc_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= is_read;
      if (is_read) rd_data_o <= rd_word;
    end
  end

  assert_write_silent_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && (|acc_lanes_i)) |=> !rd_valid_o);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce2_ni,
  input  logic              proc_stb_ni,
  input  logic              ctrl_stb_ni,
  input  logic              adv_ni,
  input  logic              byte_wr_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              all_wr_ni,
  input  logic              oe_ni,
  input  logic              interleave_i,
  input  logic              sleep_i
);
  ctl_t              ctl_in, ctl_q;
  logic [AW-1:0]     addr_q, acc_addr;
  logic [WORD_W-1:0] wdata_q, rd_data;
  logic              acc_valid, rd_valid, out_valid_q;
  logic [LANES-1:0]  acc_lanes;
  logic [WORD_W-1:0] out_data_q;

  assign ctl_in = '{ce_n: ce_ni, ce2: ce2_i, ce2_n: ce2_ni, proc_stb_n: proc_stb_ni,
                    ctrl_stb_n: ctrl_stb_ni, adv_n: adv_ni, byte_wr_n: byte_wr_ni,
                    lane_wr_n: lane_wr_ni, all_wr_n: all_wr_ni, mode: interleave_i,
                    sleep: sleep_i};

  sbs_in_reg #(.AW(AW)) u_in_reg (
    .clk_i, .rst_ni, .ctl_i(ctl_in), .addr_i, .wdata_i,
    .ctl_o(ctl_q), .addr_o(addr_q), .wdata_o(wdata_q)
  );

  sbs_burst_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .ctl_i(ctl_q), .addr_i(addr_q),
    .acc_valid_o(acc_valid), .acc_addr_o(acc_addr), .acc_lanes_o(acc_lanes)
  );

  sbs_mem #(.AW(AW)) u_mem (
    .clk_i, .rst_ni, .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_lanes_i(acc_lanes), .wdata_i(wdata_q),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= rd_valid;
      if (rd_valid) out_data_q <= rd_data;
    end
  end

  assign rdata_o    = out_data_q;
  assign rdata_oe_o = out_valid_q & ~oe_ni;

  assert_out_stage_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid |=> out_valid_q && (out_data_q == $past(rd_data)));
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic ce_n, ce2, ce2_n, psn, csn, advn, bwen;
    logic [3:0] lanen;
    logic gwn, oen, mode, zz;
  } vec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  vec_t        drv;
  logic [31:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R11";

  logic [31:0] mem_m [256];
  logic [7:0]  m_base;
  logic [1:0]  m_cnt;
  logic        m_act = 1'b0;
  logic        r1_v = 1'b0, r2_v = 1'b0;
  logic [31:0] r1_d = '0, r2_d = '0;
  vec_t        applied;

  always #2 clk = ~clk;

  sync_burst_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(drv.addr), .wdata_i(drv.data),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .ce_ni(drv.ce_n), .ce2_i(drv.ce2),
    .ce2_ni(drv.ce2_n), .proc_stb_ni(drv.psn), .ctrl_stb_ni(drv.csn),
    .adv_ni(drv.advn), .byte_wr_ni(drv.bwen), .lane_wr_ni(drv.lanen),
    .all_wr_ni(drv.gwn), .oe_ni(drv.oen), .interleave_i(drv.mode), .sleep_i(drv.zz)
  );

  function automatic vec_t idle_v();
    vec_t v;
    v = '0;
    v.ce_n = 1'b0; v.ce2 = 1'b1; v.ce2_n = 1'b0;
    v.psn = 1'b1; v.csn = 1'b1; v.advn = 1'b1; v.bwen = 1'b1;
    v.lanen = 4'hF; v.gwn = 1'b1; v.oen = 1'b0; v.mode = 1'b1;
    return v;
  endfunction

  function automatic logic [1:0] order(logic [1:0] s, logic [1:0] c, logic il);
    return il ? (s ^ c) : (s + c);
  endfunction

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // model of the access sampled at the edge just passed
  task automatic model_step(vec_t v);
    logic proc, strb, en, start, pstart;
    logic [3:0] lanes;
    logic [7:0] a;
    logic rv;
    logic [31:0] rd;
    rv = 1'b0; rd = '0; pstart = 1'b0;
    if (!v.zz) begin
      proc = !v.psn && !v.ce_n;
      strb = proc || !v.csn;
      en = !v.ce_n && v.ce2 && !v.ce2_n;
      start = strb && en;
      if (start) begin
        m_base = v.addr; m_cnt = 2'd0; m_act = 1'b1; pstart = proc;
      end else if (strb) m_act = 1'b0;
      else if (m_act && !v.advn) m_cnt = m_cnt + 2'd1;
      if (m_act) begin
        a = {m_base[7:2], order(m_base[1:0], m_cnt, v.mode)};
        lanes = !v.gwn ? 4'hF : (!v.bwen ? ~v.lanen : 4'h0);
        if (pstart) lanes = 4'h0;
        if (lanes != 0) begin
          for (int l = 0; l < 4; l++)
            if (lanes[l]) mem_m[a][l*8 +: 8] = v.data[l*8 +: 8];
        end else begin
          rv = 1'b1; rd = mem_m[a];
        end
      end
    end
    r2_v = r1_v; r2_d = r1_d;
    r1_v = rv;   r1_d = rd;
  endtask

  task automatic cyc(vec_t nv);
    @(negedge clk);
    chk({tag, " oe"}, {31'd0, rdata_oe}, {31'd0, r2_v & ~applied.oen});
    if (r2_v) chk({tag, " data"}, rdata, r2_d);
    model_step(applied);
    drv = nv;
    applied = nv;
  endtask

  initial begin
    int cyc_n = 0;
    while (!done && cyc_n < 200000) begin
      @(posedge clk);
      cyc_n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", cyc_n, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    void'($urandom(32'h1d5a_0c37));
    drv = idle_v();
    applied = drv;
    repeat (3) @(negedge clk);
    tag = "R11";
    chk("R11 reset oe", {31'd0, rdata_oe}, 32'd0);
    chk("R11 reset data", rdata, 32'd0);
    rst_n = 1'b1;

    // R7: fill every word with a global write
    tag = "R7";
    for (int a = 0; a < 256; a++) begin
      v = idle_v(); v.csn = 1'b0; v.gwn = 1'b0; v.bwen = 1'b1; v.lanen = 4'hF;
      v.addr = 8'(a); v.data = $urandom;
      cyc(v);
    end

    // R5 and R1: full read bursts, both orders
    for (int m = 0; m < 2; m++) begin
      tag = (m == 0) ? "R5" : "R1";
      v = idle_v(); v.mode = 1'(m == 0); v.psn = 1'b0; v.addr = 8'h36; cyc(v);
      for (int k = 0; k < 3; k++) begin
        v = idle_v(); v.mode = 1'(m == 0); v.advn = 1'b0; cyc(v);
      end
      v = idle_v(); v.mode = 1'(m == 0); v.ce_n = 1'b1; cyc(v); cyc(v); cyc(v);
    end

    // R11: output enable follows oe_ni without a clock
    tag = "R11";
    v = idle_v(); v.csn = 1'b0; v.addr = 8'h40; cyc(v);
    v = idle_v(); cyc(v); cyc(v);
    #1 drv.oen = 1'b1;
    #0.5 chk("R11 async oe off", {31'd0, rdata_oe}, 32'd0);
    drv.oen = 1'b0;
    #0.5 chk("R11 async oe on", {31'd0, rdata_oe}, 32'd1);

    // R3: processor strobe ignored while ce_ni high, burst continues
    tag = "R3";
    v = idle_v(); v.csn = 1'b0; v.addr = 8'h51; cyc(v);
    v = idle_v(); v.ce_n = 1'b1; v.psn = 1'b0; v.addr = 8'h99; v.advn = 1'b0; cyc(v);
    v = idle_v(); v.advn = 1'b0; cyc(v);
    v = idle_v(); v.ce_n = 1'b1; v.psn = 1'b0; v.addr = 8'h10; cyc(v); cyc(v);

    // R6: byte writes, then master disabled, then read back
    tag = "R6";
    v = idle_v(); v.csn = 1'b0; v.addr = 8'h62; v.bwen = 1'b0; v.lanen = 4'b1010;
    v.data = 32'hA1B2_C3D4; cyc(v);
    v = idle_v(); v.bwen = 1'b1; v.lanen = 4'b0000; v.data = 32'h1111_1111; cyc(v);
    v = idle_v(); cyc(v); cyc(v); cyc(v);

    // R8: processor strobe start with global write low is a read
    tag = "R8";
    v = idle_v(); v.psn = 1'b0; v.csn = 1'b0; v.gwn = 1'b0; v.addr = 8'h62;
    v.data = 32'hDEAD_BEEF; cyc(v);
    v = idle_v(); cyc(v); cyc(v); cyc(v);

    // R9 and R12: write then immediate read of the same word
    tag = "R9";
    v = idle_v(); v.csn = 1'b0; v.gwn = 1'b0; v.addr = 8'h77; v.data = 32'h0BAD_F00D; cyc(v);
    v = idle_v(); v.csn = 1'b0; v.addr = 8'h77; cyc(v);
    v = idle_v(); cyc(v); cyc(v);

    // R10: sleep blocks strobes and writes
    tag = "R10";
    v = idle_v(); v.zz = 1'b1; v.csn = 1'b0; v.gwn = 1'b0; v.addr = 8'h77;
    v.data = 32'h5555_AAAA; cyc(v); cyc(v);
    v = idle_v(); v.csn = 1'b0; v.addr = 8'h77; cyc(v);
    v = idle_v(); v.advn = 1'b0; cyc(v); cyc(v); cyc(v);

    // R2: deselect through ce2_i, then advance does nothing
    tag = "R2";
    v = idle_v(); v.csn = 1'b0; v.ce2 = 1'b0; cyc(v);
    v = idle_v(); v.advn = 1'b0; cyc(v); cyc(v); cyc(v);

    // R4: mixed random traffic
    tag = "R4";
    v = idle_v();
    for (int n = 0; n < 4000; n++) begin
      vec_t r;
      r = idle_v();
      r.addr  = 8'($urandom);
      r.data  = $urandom;
      r.ce_n  = ($urandom % 10) == 0;
      r.ce2   = ($urandom % 20) != 0;
      r.ce2_n = ($urandom % 20) == 0;
      r.psn   = ($urandom % 7) != 0;
      r.csn   = ($urandom % 7) != 0;
      r.advn  = ($urandom % 5) < 2;
      r.gwn   = ($urandom % 10) != 0;
      r.bwen  = ($urandom % 5) != 0;
      r.lanen = 4'($urandom);
      r.oen   = ($urandom % 10) == 0;
      r.zz    = ($urandom % 25) == 0;
      if (($urandom % 50) == 0) v.mode = ~v.mode;
      r.mode  = v.mode;
      cyc(r);
    end
    v = idle_v(); v.ce_n = 1'b1; cyc(v); cyc(v); cyc(v);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule